// File: doc/BRIEF.md
# Virtual address segment decoder

This combinational block sorts every 32-bit virtual address of a classic RISC core into one of its fixed address regions. It then decides, in the same cycle, what happens to the access. The address may be translated directly into a physical address, handed to the TLB, passed on unchanged, or refused with an address error. The decision depends on the current privilege level, on an error-level flag that turns the user region into an identity window, and on a mode select. That select swaps TLB lookups for a fixed-offset mapping in systems that have no TLB.

The core presents the address, the privilege level, the two flags and the load/store direction. It uses the outputs at once: a physical address with a read/write grant, a strobe asking the TLB to translate, or one of two address-error flags. The two error flags let an exception encoder choose between a load cause and a store cause. The upper three address bits select the region: 000 to 011 user, 100 first unmapped kernel window, 101 second unmapped kernel window, 110 supervisor mapped, 111 kernel mapped.

Top module: `vaseg_decoder`

## Requirements
- R1: In TLB mode (`fixed_map_i`=0) with `err_level_i`=0, any address below 0x80000000 raises `tlb_req_o` for every privilege level, with `paddr_o`=0, `rw_ok_o`=0 and no error.
- R2: With `err_level_i`=1, any address below 0x80000000 gives `paddr_o` equal to the address and `rw_ok_o`=1 in either mode, with no TLB request. This override takes precedence over the fixed offset of R9.
- R3: In kernel level, an address in 0x80000000–0x9FFFFFFF gives `paddr_o` = address − 0x80000000 and `rw_ok_o`=1.
- R4: In kernel level, an address in 0xA0000000–0xBFFFFFFF gives `paddr_o` = address − 0xA0000000 and `rw_ok_o`=1.
- R5: An address in 0xC0000000–0xDFFFFFFF raises `tlb_req_o` in TLB mode for supervisor or kernel level. It is an address error at user level.
- R6: An address in 0xE0000000–0xFFFFFFFF raises `tlb_req_o` in TLB mode for kernel level only. It is an address error at user or supervisor level.
- R7: User or supervisor level accessing 0x80000000–0xBFFFFFFF is an address error. Kernel level never sees an address error.
- R8: An address error drives `addr_err_ld_o`=1 when `is_store_i`=0 and `addr_err_st_o`=1 when `is_store_i`=1, never both. During an error `paddr_o`=0 and both `rw_ok_o` and `tlb_req_o` are 0.
- R9: In fixed mode (`fixed_map_i`=1) with `err_level_i`=0, an address below 0x80000000 gives `paddr_o` = address + 0x40000000 with `rw_ok_o`=1. `tlb_req_o` is never raised in fixed mode.
- R10: In fixed mode, a permitted access to 0xC0000000–0xFFFFFFFF passes through with `paddr_o` equal to the address and `rw_ok_o`=1. Privilege errors are the same as in TLB mode.
- R11: `priv_i` encodes 00 user, 01 supervisor and 10 kernel. The code 11 is given the rights of user level.
- R12: Every input combination yields exactly one of: `rw_ok_o`, `tlb_req_o`, `addr_err_ld_o`, `addr_err_st_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr_i | input | 32 | Virtual address of the access |
| priv_i | input | 2 | Privilege level: 00 user, 01 supervisor, 10 kernel, 11 treated as user |
| err_level_i | input | 1 | Error-level flag; makes the user region an identity window |
| fixed_map_i | input | 1 | 1 selects fixed-offset mapping instead of TLB lookups |
| is_store_i | input | 1 | 1 for a store, 0 for a load or fetch |
| paddr_o | output | 32 | Physical address when `rw_ok_o` is 1, else 0 |
| rw_ok_o | output | 1 | Access resolved directly with read and write granted |
| tlb_req_o | output | 1 | Address must be translated by the TLB |
| addr_err_ld_o | output | 1 | Address error on a load |
| addr_err_st_o | output | 1 | Address error on a store |

## Verification
The error-level override and the fixed-offset mapping both claim the user region, and both can be active for the same address. The bench provokes this by raising both flags at once, in a table entry and again across the boundary sweep. It judges the result against the precedence of R2, which expects the identity address rather than the +0x40000000 offset. The sweep also walks each region edge, including 0x7FFFFFFF/0x80000000 and 0x9FFFFFFF/0xA0000000, through all privilege codes, both flags and both directions. At every point it checks the outcome against an independent model and confirms that exactly one outcome fires.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;

    localparam int VA_W      = 32;
    localparam int REGION_W  = 3;
    localparam int LOW_W     = VA_W - REGION_W;

    localparam logic [VA_W-1:0] LOW_MASK = {{REGION_W{1'b0}}, {LOW_W{1'b1}}};

    typedef enum logic [1:0] {
        PRIV_USER   = 2'b00,
        PRIV_SUPER  = 2'b01,
        PRIV_KERNEL = 2'b10,
        PRIV_RSVD   = 2'b11
    } priv_e;

    typedef enum logic [2:0] {
        RGN_USER,
        RGN_KWIN0,
        RGN_KWIN1,
        RGN_SUPMAP,
        RGN_KERNMAP
    } region_e;

    typedef enum logic [2:0] {
        ACT_IDENT,
        ACT_OFFSET,
        ACT_LOWBITS,
        ACT_TLB,
        ACT_FAULT
    } act_e;

    typedef struct packed {
        logic kern_ok;
        logic sup_ok;
    } rights_t;

    typedef struct packed {
        logic [VA_W-1:0] paddr;
        logic            rw_ok;
        logic            tlb_req;
        logic            err_ld;
        logic            err_st;
    } result_t;

    function automatic rights_t rights_of(priv_e p);
        rights_t r;
        r.kern_ok = (p == PRIV_KERNEL);
        r.sup_ok  = (p == PRIV_KERNEL) || (p == PRIV_SUPER);
        return r;
    endfunction

    function automatic region_e region_of(logic [REGION_W-1:0] top);
        region_e rg;
        case (top)
            3'b100:  rg = RGN_KWIN0;
            3'b101:  rg = RGN_KWIN1;
            3'b110:  rg = RGN_SUPMAP;
            3'b111:  rg = RGN_KERNMAP;
            default: rg = RGN_USER;
        endcase
        return rg;
    endfunction

endpackage

// File: rtl/vaseg_region.sv
module vaseg_region
    import vaseg_pkg::*;
(
    input  logic [REGION_W-1:0] top_bits_i,
    output region_e             region_o
);
    always_comb region_o = region_of(top_bits_i);
endmodule

// File: rtl/vaseg_access.sv
module vaseg_access
    import vaseg_pkg::*;
(
    input  region_e region_i,
    input  priv_e   priv_i,
    input  logic    err_level_i,
    input  logic    fixed_map_i,
    output act_e    act_o
);
    rights_t rt;
    act_e    mapped_act;

    always_comb begin
        rt         = rights_of(priv_i);
        mapped_act = fixed_map_i ? ACT_IDENT : ACT_TLB;
        case (region_i)
            RGN_USER: begin
                if (err_level_i)      act_o = ACT_IDENT;
                else if (fixed_map_i) act_o = ACT_OFFSET;
                else                  act_o = ACT_TLB;
            end
            RGN_KWIN0,
            RGN_KWIN1:   act_o = rt.kern_ok ? ACT_LOWBITS : ACT_FAULT;
            RGN_SUPMAP:  act_o = rt.sup_ok  ? mapped_act  : ACT_FAULT;
            RGN_KERNMAP: act_o = rt.kern_ok ? mapped_act  : ACT_FAULT;
            default:     act_o = ACT_FAULT;
        endcase
    end

    // kernel rights never end in a fault (R7)
    always_comb begin
        p_kernel_no_fault_r7: assert (!(priv_i == PRIV_KERNEL && act_o == ACT_FAULT))
            else $error("kernel access faulted");
    end

    // fixed mode never asks for the TLB (R9)
    always_comb begin
        p_fixed_no_tlb_r9: assert (!(fixed_map_i && act_o == ACT_TLB))
            else $error("TLB requested in fixed mode");
    end
endmodule

// File: rtl/vaseg_xlate.sv
module vaseg_xlate
    import vaseg_pkg::*;
#(
    parameter logic [VA_W-1:0] FIX_OFFSET = 32'h4000_0000
) (
    input  logic [VA_W-1:0] vaddr_i,
    input  act_e            act_i,
    input  logic            is_store_i,
    output result_t         res_o
);
    always_comb begin
        res_o = '0;
        case (act_i)
            ACT_IDENT: begin
                res_o.paddr = vaddr_i;
                res_o.rw_ok = 1'b1;
            end
            ACT_OFFSET: begin
                res_o.paddr = vaddr_i + FIX_OFFSET;
                res_o.rw_ok = 1'b1;
            end
            ACT_LOWBITS: begin
                res_o.paddr = vaddr_i & LOW_MASK;
                res_o.rw_ok = 1'b1;
            end
            ACT_TLB: res_o.tlb_req = 1'b1;
            default: begin
                res_o.err_ld = ~is_store_i;
                res_o.err_st =  is_store_i;
            end
        endcase
    end
endmodule

// File: rtl/vaseg_decoder.sv
module vaseg_decoder
    import vaseg_pkg::*;
#(
    parameter logic [31:0] FIX_OFFSET = 32'h4000_0000
) (
    input  logic [31:0] vaddr_i,
    input  logic [1:0]  priv_i,
    input  logic        err_level_i,
    input  logic        fixed_map_i,
    input  logic        is_store_i,
    output logic [31:0] paddr_o,
    output logic        rw_ok_o,
    output logic        tlb_req_o,
    output logic        addr_err_ld_o,
    output logic        addr_err_st_o
);
    region_e region;
    act_e    act;
    result_t res;

    vaseg_region u_region (
        .top_bits_i (vaddr_i[VA_W-1 -: REGION_W]),
        .region_o   (region)
    );

    vaseg_access u_access (
        .region_i    (region),
        .priv_i      (priv_e'(priv_i)),
        .err_level_i (err_level_i),
        .fixed_map_i (fixed_map_i),
        .act_o       (act)
    );

    vaseg_xlate #(.FIX_OFFSET(FIX_OFFSET)) u_xlate (
        .vaddr_i    (vaddr_i),
        .act_i      (act),
        .is_store_i (is_store_i),
        .res_o      (res)
    );

    assign paddr_o       = res.paddr;
    assign rw_ok_o       = res.rw_ok;
    assign tlb_req_o     = res.tlb_req;
    assign addr_err_ld_o = res.err_ld;
    assign addr_err_st_o = res.err_st;

    // exactly one outcome per address (R12)
    always_comb begin
        p_one_outcome_r12: assert ($countones({rw_ok_o, tlb_req_o, addr_err_ld_o, addr_err_st_o}) == 1)
            else $error("outcome not unique");
    end

    // error direction follows the access direction (R8)
    always_comb begin
        p_err_dir_r8: assert (!(addr_err_st_o && !is_store_i) && !(addr_err_ld_o && is_store_i))
            else $error("error direction mismatch");
    end

    // error level turns the user region into identity (R2)
    always_comb begin
        p_erl_identity_r2: assert (!(err_level_i && !vaddr_i[31]) || (rw_ok_o && paddr_o == vaddr_i))
            else $error("identity window broken");
    end

    // granted accesses beyond the user region never come from user level (R7)
    always_comb begin
        p_user_high_fault_r7: assert (!(priv_i == 2'b00 && vaddr_i[31]) || addr_err_ld_o || addr_err_st_o)
            else $error("user reached high region");
    end
endmodule

// File: tb/sim_vaseg_decoder.sv
module sim_vaseg_decoder;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [31:0] vaddr;
    logic [1:0]  priv;
    logic        erl, fixm, st;
    logic [31:0] paddr;
    logic        rw_ok, tlb_req, err_ld, err_st;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    vaseg_decoder u0 (
        .vaddr_i       (vaddr),
        .priv_i        (priv),
        .err_level_i   (erl),
        .fixed_map_i   (fixm),
        .is_store_i    (st),
        .paddr_o       (paddr),
        .rw_ok_o       (rw_ok),
        .tlb_req_o     (tlb_req),
        .addr_err_ld_o (err_ld),
        .addr_err_st_o (err_st)
    );

    // {vaddr, priv, erl, fixed, store, paddr, {rw,tlb,err_ld,err_st}, req}
    localparam int NV = 20;
    localparam logic [76:0] VEC [NV] = '{
        {32'h0000_1000, 2'd0, 3'b000, 32'h0000_0000, 4'b0100, 4'd1},  // R1
        {32'h7FFF_FFFF, 2'd2, 3'b000, 32'h0000_0000, 4'b0100, 4'd1},  // R1
        {32'h1234_5678, 2'd0, 3'b100, 32'h1234_5678, 4'b1000, 4'd2},  // R2
        {32'h8000_0000, 2'd2, 3'b000, 32'h0000_0000, 4'b1000, 4'd3},  // R3
        {32'h9FFF_FFFF, 2'd2, 3'b001, 32'h1FFF_FFFF, 4'b1000, 4'd3},  // R3
        {32'hA000_0000, 2'd2, 3'b000, 32'h0000_0000, 4'b1000, 4'd4},  // R4
        {32'hBFFF_FFFC, 2'd2, 3'b001, 32'h1FFF_FFFC, 4'b1000, 4'd4},  // R4
        {32'hC000_0000, 2'd1, 3'b000, 32'h0000_0000, 4'b0100, 4'd5},  // R5
        {32'hDFFF_FFFF, 2'd0, 3'b000, 32'h0000_0000, 4'b0010, 4'd5},  // R5
        {32'hE000_0000, 2'd2, 3'b000, 32'h0000_0000, 4'b0100, 4'd6},  // R6
        {32'hFFFF_FFFF, 2'd1, 3'b001, 32'h0000_0000, 4'b0001, 4'd6},  // R6
        {32'h8000_1234, 2'd0, 3'b001, 32'h0000_0000, 4'b0001, 4'd7},  // R7
        {32'hA000_0000, 2'd1, 3'b000, 32'h0000_0000, 4'b0010, 4'd7},  // R7, R8
        {32'h0000_0010, 2'd0, 3'b010, 32'h4000_0010, 4'b1000, 4'd9},  // R9
        {32'h7FFF_FFFF, 2'd2, 3'b010, 32'hBFFF_FFFF, 4'b1000, 4'd9},  // R9
        {32'hC000_1000, 2'd1, 3'b010, 32'hC000_1000, 4'b1000, 4'd10}, // R10
        {32'hE000_0000, 2'd0, 3'b011, 32'h0000_0000, 4'b0001, 4'd10}, // R10, R8
        {32'h9000_0000, 2'd3, 3'b000, 32'h0000_0000, 4'b0010, 4'd11}, // R11
        {32'hC000_0000, 2'd3, 3'b000, 32'h0000_0000, 4'b0010, 4'd11}, // R11
        {32'h3FFF_FFFF, 2'd0, 3'b110, 32'h3FFF_FFFF, 4'b1000, 4'd2}   // R2 beats R9
    };

    // independent model: {paddr, rw, tlb, err_ld, err_st}
    function automatic logic [35:0] ref_out(logic [31:0] va, logic [1:0] p,
                                            logic e, logic f, logic s);
        logic kern, sup, fault, rw, tlb;
        logic [31:0] pa;
        kern = (p == 2'd2);
        sup  = (p == 2'd2) || (p == 2'd1);
        fault = 1'b0; rw = 1'b0; tlb = 1'b0; pa = '0;
        if (!va[31]) begin
            if (e)      begin pa = va; rw = 1'b1; end
            else if (f) begin pa = va + 32'h4000_0000; rw = 1'b1; end
            else        tlb = 1'b1;
        end else if (va[31:30] == 2'b10) begin
            if (kern) begin
                pa = va - (va[29] ? 32'hA000_0000 : 32'h8000_0000);
                rw = 1'b1;
            end else fault = 1'b1;
        end else begin
            if (va[29] ? kern : sup) begin
                if (f) begin pa = va; rw = 1'b1; end
                else   tlb = 1'b1;
            end else fault = 1'b1;
        end
        return {pa, rw, tlb, fault & ~s, fault & s};
    endfunction

    task automatic apply(logic [31:0] va, logic [1:0] p, logic e, logic f, logic s);
        @(negedge clk);
        vaddr = va; priv = p; erl = e; fixm = f; st = s;
        #1;
    endtask

    task automatic compare(string tag, logic [35:0] exp);
        checks++;
        if ({paddr, rw_ok, tlb_req, err_ld, err_st} !== exp) begin
            fails++;
            $display("FAIL %s va=%h priv=%0d erl=%0b fix=%0b st=%0b: got paddr=%h flags=%b, expected paddr=%h flags=%b",
                     tag, vaddr, priv, erl, fixm, st,
                     paddr, {rw_ok, tlb_req, err_ld, err_st}, exp[35:4], exp[3:0]);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    localparam logic [31:0] EDGES [10] = '{
        32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF, 32'hA000_0000,
        32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF, 32'hE000_0000, 32'hFFFF_FFFF
    };

    initial begin
        vaddr = '0; priv = '0; erl = 1'b0; fixm = 1'b0; st = 1'b0;

        // idle inputs: user level, address 0, TLB mode -> TLB request (R1)
        apply(32'h0, 2'd0, 1'b0, 1'b0, 1'b0);
        compare("R1 idle", {32'h0, 4'b0100});

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][76:45], VEC[i][44:43], VEC[i][42], VEC[i][41], VEC[i][40]);
            compare($sformatf("R%0d table[%0d]", VEC[i][3:0], i), {VEC[i][39:8], VEC[i][7:4]});
        end

        // boundary sweep over all modes; model covers R1..R11, one-hot is R12
        for (int a = 0; a < 10; a++)
            for (int p = 0; p < 4; p++)
                for (int m = 0; m < 8; m++) begin
                    apply(EDGES[a], 2'(p), m[2], m[1], m[0]);
                    compare("R12 sweep model", ref_out(EDGES[a], 2'(p), m[2], m[1], m[0]));
                    checks++;
                    if ($countones({rw_ok, tlb_req, err_ld, err_st}) != 1) begin
                        fails++;
                        $display("FAIL R12 one-hot va=%h: got flags=%b, expected one bit set",
                                 vaddr, {rw_ok, tlb_req, err_ld, err_st});
                    end
                end

        // R8: direction flip on the same faulting address
        apply(32'hE000_0040, 2'd1, 1'b0, 1'b0, 1'b0);
        compare("R8 load error", {32'h0, 4'b0010});
        apply(32'hE000_0040, 2'd1, 1'b0, 1'b0, 1'b1);
        compare("R8 store error", {32'h0, 4'b0001});

        // R2 vs R9 corner: both flags on top of user region
        apply(32'h7FFF_FFFF, 2'd0, 1'b1, 1'b1, 1'b1);
        compare("R2 override with fixed", {32'h7FFF_FFFF, 4'b1000});

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

endmodule